// File: doc/BRIEF.md
# Interrupt Pending/Enable/Status Register Block

This block keeps the interrupt state of one function unit inside a larger accelerator. Event logic in the unit sends single-cycle raise and clear vectors into a pending register. Software sees four 32-bit registers through a small request/response register port:

- a pending register it can read and write;
- a write-one-to-clear register;
- an enable register;
- a read-only status word, which is pending ANDed with enable.

The block drives a level interrupt that is high whenever the status word is non-zero. A one-cycle change pulse marks every real flip of that level.

A second port gives a debug or checkpoint agent direct access to the pending and enable storage. Reads on this port are combinational. Writes on this port land in the storage without clear semantics and without a change pulse, so saved state can be restored silently.

The register port uses valid/ready in both directions. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Each accepted request, read or write, produces exactly one response beat. The block can hold one response. `req_ready` is low while an undelivered response is waiting and `rsp_ready` is low. A response stays valid with stable data until `rsp_ready` takes it.

Top module: `irq_regblk`

## Requirements
- R1: After reset the pending and enable registers hold zero, `irq_o` and `chg_o` are low, and `rsp_valid` is low.
- R2: The pending register is at byte offset 0x00 and the enable register at 0x08. Both are read/write, and a write replaces all 32 bits.
- R3: A read of offset 0x0C returns pending AND enable. A write to 0x0C changes neither pending nor enable.
- R4: Writing to offset 0x04 clears each pending bit where the write data has a one and leaves the other bits alone. A read of 0x04 returns zero.
- R5: A read of any offset other than 0x00, 0x04, 0x08 or 0x0C, including offsets not a multiple of four, returns zero. A write to such an offset changes no register.
- R6: `irq_o` is high exactly when pending AND enable is non-zero.
- R7: Each set bit of `hw_set_i` becomes pending at the edge where it is sampled. Each set bit of `hw_clr_i` is cleared there. When both name the same bit in one cycle, the bit ends up pending.
- R8: When `irq_o` flips at clock edge E, `chg_o` is high for exactly the cycle after edge E+1. A raise that leaves `irq_o` unchanged gives no pulse; this covers a bit already pending and a bit not enabled.
- R9: When `dbg_we` is high, `dbg_wdata` is written at the clock edge to the register picked by `dbg_addr` (0x00 pending, 0x08 enable); other offsets are ignored. `dbg_rdata` returns the same read values as the bus port, combinationally. A debug write never produces a `chg_o` pulse. A debug write that lands at the same edge as a bus change suppresses that change's pulse as well.
- R10: Every accepted request gets one response, with read data for reads and zero for writes. `req_ready` equals `!rsp_valid || rsp_ready`. A response holds `rsp_valid` and `rsp_rdata` stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this edge when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset from block base |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data, zero for writes |
| hw_set_i | input | 32 | Per-bit raise pulses from event logic |
| hw_clr_i | input | 32 | Per-bit clear pulses from event logic |
| dbg_we | input | 1 | Debug write enable |
| dbg_addr | input | 6 | Debug byte offset |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data, combinational |
| irq_o | output | 1 | Level interrupt |
| chg_o | output | 1 | One-cycle pulse on interrupt level change |

## Verification
A bus request accepted at edge E returns its response in the cycle after E. The register update from a write, or from a hardware or debug pulse, is also visible in the cycle after E, and so is the new `irq_o` level. `chg_o` comes one cycle later, after edge E+1, and must be gone after E+2.

The bench drives every input on the falling edge and samples on the next falling edge. It reads state back through the bus or debug ports only after the edge that commits it. The strobe is checked on each of three consecutive falling edges so that both an early pulse and a late pulse are caught. Sweeps walk a one through all 32 bit positions, for plain storage and for the masking and clear logic.

// File: rtl/irq_regblk_pkg.sv
package irq_regblk_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SLOT_N = 4;

  // word index inside the block, taken from byte offset bits [3:2]
  typedef enum logic [1:0] {
    SLOT_PEND = 2'd0,
    SLOT_CLR  = 2'd1,
    SLOT_EN   = 2'd2,
    SLOT_STAT = 2'd3
  } slot_e;
endpackage

// File: rtl/irq_decode.sv
module irq_decode
  import irq_regblk_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output slot_e             slot
);
  logic upper_zero;

  generate
    if (ADDR_W > 4) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:4] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign hit  = upper_zero && (addr[1:0] == 2'b00);
  assign slot = slot_e'(addr[3:2]);
endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
  import irq_regblk_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DW-1:0]     rd_value,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              accept
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign req_ready = !vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = vld_q;
  assign rsp_rdata = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      dat_q <= req_write ? '0 : rd_value;
    end else if (rsp_ready) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_store.sv
module irq_store #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_pend,
  input  logic          bus_wr_clr,
  input  logic          bus_wr_en,
  input  logic [DW-1:0] bus_data,
  input  logic          bd_wr_pend,
  input  logic          bd_wr_en,
  input  logic [DW-1:0] bd_data,
  input  logic [DW-1:0] hw_set,
  input  logic [DW-1:0] hw_clr,
  output logic [DW-1:0] pend_q,
  output logic [DW-1:0] en_q
);
  logic [DW-1:0] pend_d;
  logic [DW-1:0] en_d;

  always_comb begin
    pend_d = pend_q;
    if (bus_wr_pend) pend_d = bus_data;
    if (bus_wr_clr)  pend_d = pend_d & ~bus_data;
    pend_d = pend_d & ~hw_clr;
    if (bd_wr_pend)  pend_d = bd_data;
    // raise applied last so an event is never lost
    pend_d = pend_d | hw_set;

    en_d = en_q;
    if (bus_wr_en) en_d = bus_data;
    if (bd_wr_en)  en_d = bd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end
endmodule

// File: rtl/irq_notify.sv
module irq_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic quiet,
  output logic pulse
);
  logic prev_q;
  logic quiet_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      quiet_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= (level != prev_q) && !quiet_q;
      prev_q  <= level;
      quiet_q <= quiet;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/irq_regblk.sv
module irq_regblk
  import irq_regblk_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DW     = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [DW-1:0]     hw_set_i,
  input  logic [DW-1:0]     hw_clr_i,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DW-1:0]     dbg_wdata,
  output logic [DW-1:0]     dbg_rdata,
  output logic              irq_o,
  output logic              chg_o
);
  logic          bus_hit, dbg_hit, accept;
  slot_e         bus_slot, dbg_slot;
  logic [DW-1:0] pend_q, en_q, stat;
  logic [DW-1:0] bus_rd;
  logic          bus_wr;

  irq_decode #(.ADDR_W(ADDR_W)) u_dec_bus (.addr(req_addr), .hit(bus_hit), .slot(bus_slot));
  irq_decode #(.ADDR_W(ADDR_W)) u_dec_dbg (.addr(dbg_addr), .hit(dbg_hit), .slot(dbg_slot));

  function automatic logic [DW-1:0] view(input logic hit, input slot_e s,
                                         input logic [DW-1:0] p, input logic [DW-1:0] e);
    logic [DW-1:0] v;
    v = '0;
    if (hit) begin
      case (s)
        SLOT_PEND: v = p;
        SLOT_EN:   v = e;
        SLOT_STAT: v = p & e;
        default:   v = '0;
      endcase
    end
    return v;
  endfunction

  assign stat      = pend_q & en_q;
  assign bus_rd    = view(bus_hit, bus_slot, pend_q, en_q);
  assign dbg_rdata = view(dbg_hit, dbg_slot, pend_q, en_q);
  assign irq_o     = |stat;
  assign bus_wr    = accept && req_write && bus_hit;

  irq_bus_port #(.ADDR_W(ADDR_W), .DW(DW)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .rd_value(bus_rd),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .accept(accept)
  );

  irq_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_pend(bus_wr && bus_slot == SLOT_PEND),
    .bus_wr_clr (bus_wr && bus_slot == SLOT_CLR),
    .bus_wr_en  (bus_wr && bus_slot == SLOT_EN),
    .bus_data(req_wdata),
    .bd_wr_pend(dbg_we && dbg_hit && dbg_slot == SLOT_PEND),
    .bd_wr_en  (dbg_we && dbg_hit && dbg_slot == SLOT_EN),
    .bd_data(dbg_wdata),
    .hw_set(hw_set_i), .hw_clr(hw_clr_i),
    .pend_q(pend_q), .en_q(en_q)
  );

  irq_notify u_notify (
    .clk(clk), .rst_n(rst_n),
    .level(irq_o), .quiet(dbg_we),
    .pulse(chg_o)
  );
endmodule

// File: rtl/irq_regblk_chk.sv
module irq_regblk_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DW-1:0]     rsp_rdata,
  input logic [DW-1:0]     hw_set_i,
  input logic              dbg_we,
  input logic              irq_o,
  input logic              chg_o,
  input logic [DW-1:0]     pend_q,
  input logic [DW-1:0]     en_q
);
  // R8
  pulse_on_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> ($past(irq_o, 2) != $past(irq_o, 1)));

  // R7
  raise_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set_i != '0) |=> ((pend_q & $past(hw_set_i)) == $past(hw_set_i)));

  // R9
  dbg_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we |=> ##1 !chg_o);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10
  req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R3
  stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == 6'h0C && !dbg_we && hw_set_i == '0)
      |=> ($stable(en_q) && (pend_q & ~$past(pend_q)) == '0));

  // R6
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
endmodule

bind irq_regblk irq_regblk_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .hw_set_i(hw_set_i), .dbg_we(dbg_we),
  .irq_o(irq_o), .chg_o(chg_o),
  .pend_q(pend_q), .en_q(en_q)
);

// File: tb/tb_irq_regblk.sv
`timescale 1ns/1ps
module tb_irq_regblk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic        req_ready, rsp_valid;
  logic [5:0]  req_addr = '0, dbg_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata, hw_set_i = '0, hw_clr_i = '0;
  logic        dbg_we = 1'b0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic        irq_o, chg_o;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  irq_regblk dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .hw_set_i(hw_set_i), .hw_clr_i(hw_clr_i),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .irq_o(irq_o), .chg_o(chg_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; rsp_ready assumed high; data returned the cycle after acceptance
  task automatic bus(input logic wr, input logic [5:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] r;
    bus(1'b1, a, d, r);
    check("R10 write response data", r, 32'h0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 chg", {31'b0, chg_o}, 32'h0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    for (int k = 0; k < 4; k++) begin
      bus(1'b0, 6'(k * 4), 0, rd);
      check("R1 register zero", rd, 32'h0);
    end

    // R2 R3 R6 walking-one sweep with fixed enable pattern
    wr(6'h08, 32'hA5C3_0F96);
    for (int i = 0; i < 32; i++) begin
      pat = 32'h1 << i;
      wr(6'h00, pat);
      bus(1'b0, 6'h00, 0, rd); check("R2 pending readback", rd, pat);
      bus(1'b0, 6'h0C, 0, rd); check("R3 status", rd, pat & 32'hA5C3_0F96);
      check("R6 irq level", {31'b0, irq_o}, {31'b0, |(pat & 32'hA5C3_0F96)});
    end
    wr(6'h08, 32'h1234_5678);
    bus(1'b0, 6'h08, 0, rd); check("R2 enable readback", rd, 32'h1234_5678);

    // R4 write-one-to-clear sweep
    for (int i = 0; i < 32; i++) begin
      wr(6'h00, 32'hFFFF_FFFF);
      pat = (32'h3 << i) ^ 32'h8000_0001;
      wr(6'h04, pat);
      bus(1'b0, 6'h00, 0, rd); check("R4 clear result", rd, ~pat);
    end
    bus(1'b0, 6'h04, 0, rd); check("R4 clear reads zero", rd, 32'h0);

    // R3 status write ignored
    wr(6'h00, 32'h0000_00F0);
    wr(6'h0C, 32'hFFFF_FFFF);
    bus(1'b0, 6'h00, 0, rd); check("R3 pending after status write", rd, 32'h0000_00F0);
    bus(1'b0, 6'h08, 0, rd); check("R3 enable after status write", rd, 32'h1234_5678);

    // R5 unmapped offsets
    for (int a = 16; a < 64; a += 3) begin
      wr(6'(a), 32'hFFFF_FFFF);
      bus(1'b0, 6'(a), 0, rd); check("R5 unmapped read", rd, 32'h0);
    end
    bus(1'b0, 6'h00, 0, rd); check("R5 pending untouched", rd, 32'h0000_00F0);
    bus(1'b0, 6'h08, 0, rd); check("R5 enable untouched", rd, 32'h1234_5678);

    // R7 hardware raise and clear, raise wins
    wr(6'h00, 32'h0000_FF00);
    @(negedge clk);
    hw_set_i = 32'h0000_0011; hw_clr_i = 32'h0000_0F01;
    @(negedge clk);
    hw_set_i = '0; hw_clr_i = '0;
    bus(1'b0, 6'h00, 0, rd); check("R7 raise/clear merge", rd, 32'h0000_F011);

    // R8 strobe timing
    wr(6'h00, 32'h0);
    wr(6'h08, 32'h0000_0001);
    repeat (3) @(negedge clk);
    check("R8 idle", {31'b0, chg_o}, 32'h0);
    hw_set_i = 32'h1;
    @(negedge clk);
    hw_set_i = '0;
    check("R6 irq up", {31'b0, irq_o}, 32'h1);
    check("R8 no pulse at flip", {31'b0, chg_o}, 32'h0);
    @(negedge clk); check("R8 pulse", {31'b0, chg_o}, 32'h1);
    @(negedge clk); check("R8 pulse ends", {31'b0, chg_o}, 32'h0);
    hw_set_i = 32'h3;  // bit0 already pending, bit1 not enabled
    @(negedge clk); hw_set_i = '0;
    @(negedge clk); check("R8 no pulse redundant raise", {31'b0, chg_o}, 32'h0);
    @(negedge clk); check("R8 still none", {31'b0, chg_o}, 32'h0);
    hw_clr_i = 32'h1;
    @(negedge clk); hw_clr_i = '0;
    check("R6 irq down", {31'b0, irq_o}, 32'h0);
    @(negedge clk); check("R8 pulse on fall", {31'b0, chg_o}, 32'h1);

    // R9 debug port
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = 6'h00; dbg_wdata = 32'h0000_0005;
    @(negedge clk);
    dbg_we = 1'b0;
    check("R9 irq after debug write", {31'b0, irq_o}, 32'h1);
    check("R9 no pulse", {31'b0, chg_o}, 32'h0);
    @(negedge clk); check("R9 no pulse later", {31'b0, chg_o}, 32'h0);
    dbg_addr = 6'h0C; #1 check("R9 debug status read", dbg_rdata, 32'h0000_0001);
    dbg_addr = 6'h04; #1 check("R9 debug clear read", dbg_rdata, 32'h0);
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = 6'h04; dbg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    dbg_we = 1'b0;
    bus(1'b0, 6'h00, 0, rd); check("R9 debug clear write ignored", rd, 32'h0000_0005);
    dbg_addr = 6'h08; #1 check("R9 debug enable read", dbg_rdata, 32'h0000_0001);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h00;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 response valid", {31'b0, rsp_valid}, 32'h1);
    check("R10 ready low while held", {31'b0, req_ready}, 32'h0);
    repeat (3) @(negedge clk);
    check("R10 response held", rsp_rdata, 32'h0000_0005);
    check("R10 valid held", {31'b0, rsp_valid}, 32'h1);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 response taken", {31'b0, rsp_valid}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule